// File: doc/BRIEF.md
# Two-Client Memory Request Arbiter

This block sits between two streaming clients and the single request port of an SDRAM controller. One client reads frame data for a display path. The other writes captured frame data into memory. The controller accepts only one burst at a time, so the arbiter picks one client, forwards that client's address and direction, and steers the controller's strobes back to that client alone.

The arbiter holds off until the controller reports that its power-up sequence has finished. From then on it looks at both request lines in the same cycle. When both clients ask at once, the read client wins, because the display path must never run dry. The choice is registered, so the address and direction multiplexers keep the same select from the request through the last beat of the burst. For a write, the arbiter produces the take-data strobe itself: it emits exactly one strobe per beat, starting the cycle after the controller accepts the request. The write data is passed straight through to the controller's write bus during those beats.

Top module: `mem_port_arbiter`

## Requirements
- R1: While `ctlInitDone` has never been seen high, `memReq`, both client grant outputs and `wrClientTake` stay low, whatever the clients request.
- R2: In the polling state, a client request sampled at a clock edge makes `memReq` high from that edge on. `memAddr` then carries the chosen client's address.
- R3: When both clients request in the same sampled cycle, the read client is chosen, and `memWrite` is 0. When only the write client requests, `memWrite` is 1.
- R4: When neither client requests, `memReq` stays low and the request lines are sampled again on every following cycle.
- R5: `memReq` stays high until the cycle in which `memAck` is high, and is low from the next cycle until the burst has ended. Only one request is outstanding at any time.
- R6: `rdClientGrant` and `wrClientGrant` are high only in a cycle where `memAck` is high, and only for the chosen client.
- R7: After a write request is accepted, `wrClientTake` is high for exactly `BURST_LEN` consecutive cycles, starting the cycle after the `memAck` cycle. During those cycles `memWrData` equals `wrClientData`.
- R8: `rdClientValid` follows `memRdValid` only during a read burst. It is forced low during a write burst, and `wrClientTake` is low during a read burst.
- R9: `memAddr` and `memWrite` stay stable from the first cycle of `memReq` until the burst ends.
- R10: A burst ends at the first clock edge where `memDone` is high and every write beat has been taken. The arbiter is then back in the polling state: a request sampled on the next edge raises `memReq` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlInitDone | input | 1 | Controller has finished its power-up sequence |
| rdClientReq | input | 1 | Read client requests a burst |
| rdClientAddr | input | ADDR_W | Read client burst address |
| rdClientGrant | output | 1 | Read client request accepted (one cycle) |
| rdClientValid | output | 1 | Read beat valid for the read client |
| rdClientData | output | DATA_W | Read beat data |
| wrClientReq | input | 1 | Write client requests a burst |
| wrClientAddr | input | ADDR_W | Write client burst address |
| wrClientData | input | DATA_W | Write beat data from the write client |
| wrClientGrant | output | 1 | Write client request accepted (one cycle) |
| wrClientTake | output | 1 | Write client must present its next beat |
| memReq | output | 1 | Request to the controller |
| memWrite | output | 1 | Direction of the request, 1 = write |
| memAddr | output | ADDR_W | Burst address to the controller |
| memAck | input | 1 | Controller accepts the request |
| memWrData | output | DATA_W | Write data to the controller |
| memRdData | input | DATA_W | Read data from the controller |
| memRdValid | input | 1 | Read beat strobe from the controller |
| memDone | input | 1 | Controller burst has completed |

## Verification
A request sampled at an edge in the polling state shows on `memReq`, `memAddr` and `memWrite` one edge later. The bench drives each request on a falling edge and checks these outputs on the next falling edge. Grants and read-valid steering are combinational, so the bench checks them one time unit after it drives `memAck` or `memRdValid` within the same half cycle. The take strobe begins one edge after the acknowledge and is checked on each of the following `BURST_LEN` falling edges, then checked low once more. After `memDone`, a fresh request must raise `memReq` exactly one edge later, which proves the return to polling.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [2:0] {
    ST_BOOT,
    ST_POLL,
    ST_ASK_RD,
    ST_ASK_WR,
    ST_BURST
  } arbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic reqOn;    // request presented to controller
    logic selWr;    // registered winner: 1 = write client
    logic takeOn;   // write beat take window
    logic validOn;  // read beat steering window
  } arbStrobes_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int BURST_LEN = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctlInitDone,
  input  logic        rdReq,
  input  logic        wrReq,
  input  logic        memAck,
  input  logic        memDone,
  output arbStrobes_t strobes
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);
  localparam logic [CNT_W-1:0] BEATS = CNT_W'(BURST_LEN);

  arbState_t state, stateNext;
  logic             selWr;
  logic [CNT_W-1:0] beatCnt;
  logic             doneSeen;
  logic             burstOver;

  assign burstOver = (memDone || doneSeen) && (beatCnt == '0);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_BOOT:   if (ctlInitDone) stateNext = ST_POLL;
      ST_POLL: begin
        if (rdReq)      stateNext = ST_ASK_RD;
        else if (wrReq) stateNext = ST_ASK_WR;
      end
      ST_ASK_RD,
      ST_ASK_WR: if (memAck) stateNext = ST_BURST;
      ST_BURST:  if (burstOver) stateNext = ST_POLL;
      default:   stateNext = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_BOOT;
      selWr    <= 1'b0;
      beatCnt  <= '0;
      doneSeen <= 1'b0;
    end else begin
      state <= stateNext;
      // the winner is latched once and held for the whole grant
      if (state == ST_POLL && (rdReq || wrReq))
        selWr <= !rdReq;
      if (state == ST_ASK_WR && memAck)
        beatCnt <= BEATS;
      else if (state == ST_BURST && beatCnt != '0)
        beatCnt <= beatCnt - 1'b1;
      if (state == ST_BURST && stateNext == ST_POLL)
        doneSeen <= 1'b0;
      else if (state == ST_BURST && memDone)
        doneSeen <= 1'b1;
    end
  end

  always_comb begin
    strobes.reqOn   = (state == ST_ASK_RD) || (state == ST_ASK_WR);
    strobes.selWr   = selWr;
    strobes.takeOn  = (state == ST_BURST) && (beatCnt != '0);
    strobes.validOn = (state == ST_BURST) && !selWr;
  end
endmodule

// File: rtl/arb_dpath.sv
module arb_dpath
  import arb_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 32
) (
  input  arbStrobes_t       strobes,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              memRdValid,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              rdGrant,
  output logic              wrGrant,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              wrTake
);
  assign memReq    = strobes.reqOn;
  assign memWrite  = strobes.selWr;
  assign memAddr   = strobes.selWr ? wrAddr : rdAddr;
  assign memWrData = wrData;

  // acknowledge and beat strobes reach only the chosen client
  assign rdGrant = strobes.reqOn && !strobes.selWr && memAck;
  assign wrGrant = strobes.reqOn &&  strobes.selWr && memAck;
  assign rdValid = strobes.validOn && memRdValid;
  assign rdData  = memRdData;
  assign wrTake  = strobes.takeOn;
endmodule

// File: rtl/mem_port_arbiter.sv
module mem_port_arbiter
  import arb_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlInitDone,
  input  logic              rdClientReq,
  input  logic [ADDR_W-1:0] rdClientAddr,
  output logic              rdClientGrant,
  output logic              rdClientValid,
  output logic [DATA_W-1:0] rdClientData,
  input  logic              wrClientReq,
  input  logic [ADDR_W-1:0] wrClientAddr,
  input  logic [DATA_W-1:0] wrClientData,
  output logic              wrClientGrant,
  output logic              wrClientTake,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              memRdValid,
  input  logic              memDone
);
  arbStrobes_t strobes;

  arb_ctrl #(.BURST_LEN(BURST_LEN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctlInitDone(ctlInitDone),
    .rdReq      (rdClientReq),
    .wrReq      (wrClientReq),
    .memAck     (memAck),
    .memDone    (memDone),
    .strobes    (strobes)
  );

  arb_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .strobes   (strobes),
    .rdAddr    (rdClientAddr),
    .wrAddr    (wrClientAddr),
    .wrData    (wrClientData),
    .memAck    (memAck),
    .memRdData (memRdData),
    .memRdValid(memRdValid),
    .memReq    (memReq),
    .memWrite  (memWrite),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .rdGrant   (rdClientGrant),
    .wrGrant   (wrClientGrant),
    .rdValid   (rdClientValid),
    .rdData    (rdClientData),
    .wrTake    (wrClientTake)
  );
endmodule

// File: rtl/mem_port_arbiter_chk.sv
module mem_port_arbiter_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctlInitDone,
  input logic              memReq,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck,
  input logic              memRdValid,
  input logic              rdClientGrant,
  input logic              wrClientGrant,
  input logic              rdClientValid,
  input logic              wrClientTake
);
  logic initSeen;
  always_ff @(posedge clk) begin
    if (!rstN) initSeen <= 1'b0;
    else if (ctlInitDone) initSeen <= 1'b1;
  end

  p_init_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    !initSeen |-> (!memReq && !wrClientTake && !rdClientGrant && !wrClientGrant));

  p_req_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);

  p_one_outstanding_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> !memReq);

  p_grant_route_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdClientGrant || wrClientGrant) |-> (memAck && memReq &&
      $onehot0({rdClientGrant, wrClientGrant}) && (wrClientGrant == memWrite)));

  p_strobe_split_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrClientTake |-> !rdClientValid);

  p_valid_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdClientValid |-> memRdValid);

  p_stable_sel_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> ($stable(memAddr) && $stable(memWrite)));
endmodule

bind mem_port_arbiter mem_port_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .ctlInitDone  (ctlInitDone),
  .memReq       (memReq),
  .memWrite     (memWrite),
  .memAddr      (memAddr),
  .memAck       (memAck),
  .memRdValid   (memRdValid),
  .rdClientGrant(rdClientGrant),
  .wrClientGrant(wrClientGrant),
  .rdClientValid(rdClientValid),
  .wrClientTake (wrClientTake)
);

// File: tb/mem_port_arbiter_bench.sv
`timescale 1ns/1ps
module mem_port_arbiter_bench;
  localparam int ADDR_W = 22;
  localparam int DATA_W = 32;
  localparam int BURST_LEN = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlInitDone = 1'b0;
  logic rdClientReq = 1'b0, wrClientReq = 1'b0;
  logic [ADDR_W-1:0] rdClientAddr = '0, wrClientAddr = '0;
  logic [DATA_W-1:0] wrClientData = '0, memRdData = '0;
  logic memAck = 1'b0, memRdValid = 1'b0, memDone = 1'b0;
  logic rdClientGrant, rdClientValid, wrClientGrant, wrClientTake;
  logic memReq, memWrite;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] rdClientData, memWrData;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mem_port_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_LEN(BURST_LEN)) u_mem_port_arbiter (
    .clk(clk), .rstN(rstN), .ctlInitDone(ctlInitDone),
    .rdClientReq(rdClientReq), .rdClientAddr(rdClientAddr),
    .rdClientGrant(rdClientGrant), .rdClientValid(rdClientValid), .rdClientData(rdClientData),
    .wrClientReq(wrClientReq), .wrClientAddr(wrClientAddr), .wrClientData(wrClientData),
    .wrClientGrant(wrClientGrant), .wrClientTake(wrClientTake),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memAck(memAck),
    .memWrData(memWrData), .memRdData(memRdData), .memRdValid(memRdValid), .memDone(memDone)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected winner: 1 means the write client
  function automatic bit expectWrite(bit rdOn, bit wrOn);
    return !rdOn && wrOn;
  endfunction

  function automatic logic [ADDR_W-1:0] expectAddr(bit rdOn, bit wrOn,
      logic [ADDR_W-1:0] ra, logic [ADDR_W-1:0] wa);
    return expectWrite(rdOn, wrOn) ? wa : ra;
  endfunction

  // entered at a falling edge with the arbiter polling; at least one request on
  task automatic runTxn(bit rdOn, bit wrOn, int ackWait, int doneWait);
    logic [ADDR_W-1:0] ra = ADDR_W'($urandom);
    logic [ADDR_W-1:0] wa = ADDR_W'($urandom);
    bit expWr = expectWrite(rdOn, wrOn);
    logic [ADDR_W-1:0] expA = expectAddr(rdOn, wrOn, ra, wa);
    rdClientReq = rdOn; wrClientReq = wrOn;
    rdClientAddr = ra;  wrClientAddr = wa;
    #1 chk("R4 no request yet", 64'(memReq), 64'd0);
    @(negedge clk);
    chk("R2 request raised", 64'(memReq), 64'd1);
    chk("R3 direction", 64'(memWrite), 64'(expWr));
    chk("R2 address", 64'(memAddr), 64'(expA));
    for (int i = 0; i < ackWait; i++) begin
      @(negedge clk);
      chk("R5 request held", 64'(memReq), 64'd1);
      chk("R9 address stable", 64'(memAddr), 64'(expA));
      chk("R6 no early grant", 64'({rdClientGrant, wrClientGrant}), 64'd0);
    end
    memAck = 1'b1;
    #1 chk("R6 grant routing", 64'({rdClientGrant, wrClientGrant}), 64'({!expWr, expWr}));
    @(negedge clk);
    memAck = 1'b0; rdClientReq = 1'b0; wrClientReq = 1'b0;
    for (int b = 0; b < BURST_LEN; b++) begin
      logic [DATA_W-1:0] d = $urandom;
      memRdValid = 1'b1;
      if (expWr) wrClientData = d; else memRdData = d;
      #1;
      chk("R5 no second request", 64'(memReq), 64'd0);
      chk("R9 direction stable", 64'(memWrite), 64'(expWr));
      chk("R9 address stable in burst", 64'(memAddr), 64'(expA));
      if (expWr) begin
        chk("R7 take beat", 64'(wrClientTake), 64'd1);
        chk("R7 write data", 64'(memWrData), 64'(d));
        chk("R8 read valid blocked", 64'(rdClientValid), 64'd0);
      end else begin
        chk("R8 read valid", 64'(rdClientValid), 64'd1);
        chk("R8 read data", 64'(rdClientData), 64'(d));
        chk("R8 take blocked", 64'(wrClientTake), 64'd0);
      end
      @(negedge clk);
    end
    memRdValid = 1'b0;
    for (int i = 0; i < doneWait; i++) begin
      #1 chk("R7 take ended", 64'(wrClientTake), 64'd0);
      chk("R10 no request before done", 64'(memReq), 64'd0);
      @(negedge clk);
    end
    #1 chk("R7 exactly burst beats", 64'(wrClientTake), 64'd0);
    memDone = 1'b1;
    @(negedge clk);
    memDone = 1'b0;
  endtask

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: requests ignored before the controller is ready
    rdClientReq = 1'b1; wrClientReq = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R1 gated before init", 64'({memReq, rdClientGrant, wrClientGrant, wrClientTake}), 64'd0);
    end
    rdClientReq = 1'b0; wrClientReq = 1'b0;
    ctlInitDone = 1'b1;
    @(negedge clk);
    // R4: idle polling
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R4 idle stays low", 64'(memReq), 64'd0);
    end
    // directed corners
    runTxn(1'b1, 1'b1, 0, 0);  // R3 both, read wins
    runTxn(1'b0, 1'b1, 2, 0);  // write alone
    runTxn(1'b1, 1'b0, 0, 3);  // read alone, late done
    runTxn(1'b1, 1'b1, 3, 1);  // R10 back-to-back
    runTxn(1'b0, 1'b1, 0, 2);
    // constrained random mix
    for (int n = 0; n < 80; n++) begin
      int kind = $urandom_range(0, 3);
      int gap = $urandom_range(0, 3);
      for (int g = 0; g < gap; g++) begin
        #1 chk("R4 idle gap", 64'(memReq), 64'd0);
        @(negedge clk);
      end
      case (kind)
        0: runTxn(1'b1, 1'b0, $urandom_range(0, 4), $urandom_range(0, 2));
        1: runTxn(1'b0, 1'b1, $urandom_range(0, 4), $urandom_range(0, 2));
        default: runTxn(1'b1, 1'b1, $urandom_range(0, 4), $urandom_range(0, 2));
      endcase
    end
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule